// File: doc/BRIEF.md
# Center-Scan Vertical Sweep Sequencer

This block generates the vertical phase requests for an interline sensor across one frame. Besides plain progressive readout of every line, it supports two partial-frame center-scan modes. In these modes, the lines outside the wanted central window are dumped by bursts of fast vertical transfers. Only the kept lines are then clocked out at the normal line rate. The frame gets shorter, so the frame rate rises.

A frame starts on a vertical-sync pulse (`vd_i`). The scan mode is captured on that pulse only. Each center-scan frame runs in a fixed order:

1. A sweep burst.
2. One readout line.
3. A frame-shift burst.
4. The kept output lines.
5. Blank lines to the end of the frame.

Every burst lasts a whole number of line periods. The fast-transfer period is the burst length in clocks divided by its transfer count, rounded down. The clocks left over are idle at the end of the burst. A burst flag marks every burst line, so that the pixel-valid path stays low during it. Horizontal clocking is shared with the base timing generator and is not part of this block.

Top module: `cs_vsweep`

## Requirements
- R1: After reset, and until the first `vd_i` pulse, the phase outputs hold the rest state (v1=0, v2=1, v3=1), `burst_o`, `pix_valid_o` and `readout_o` are low, and `line_o` and `mode_o` are 0.
- R2: `mode_i` is captured only in a cycle where `vd_i` is high. The codes are 0 = full progressive, 1 = 222-line window, 2 = 76-line window, and 3 = taken as full. `mode_o` shows the captured code from the next cycle on. `mode_i` has no effect at any other time.
- R3: A frame lasts 525 lines in full mode, 262 lines in mode 1 and 131 lines in mode 2, each line being LINE_CLKS clocks. After the last clock of the last line, `line_o` returns to 0 and the frame repeats without a new `vd_i`.
- R4: In modes 1 and 2, lines 0 to SW-1 are a sweep burst with `burst_o` high. SW is 16 in mode 1 and 24 in mode 2. The burst holds N fast transfers, N being 167 in mode 1 and 255 in mode 2. The period is P = floor(SW*LINE_CLKS/N). Each transfer drives phase "one" (v1=1, v2=0, v3=0) for floor(P/2) clocks, then phase "two" (v1=0, v2=1, v3=0) for the rest of its period. The clocks left after N transfers are in the rest state.
- R5: The readout line is line SW in modes 1 and 2, and line 0 in full mode. On it, `readout_o` is high for the first READ_CLKS clocks, the phases stay in the rest state, and `burst_o` and `pix_valid_o` are low.
- R6: In modes 1 and 2, the FS lines after the readout line are a frame-shift burst. FS is 14 lines with 142 transfers in mode 1, and 20 lines with 215 transfers in mode 2. The same transfer rules as R4 apply, counted from the first clock of the burst.
- R7: After the frame shift (in full mode, after line 0), come the kept output lines: 222 in mode 1, 76 in mode 2 and 494 in full mode. On each of them `pix_valid_o` is high for the whole line. The phases show phase "one" for clocks 0 to XFER_CLKS-1, then phase "two" for the next XFER_CLKS clocks, then the rest state.
- R8: The remaining lines of the frame are blank: rest state, with `burst_o`, `pix_valid_o` and `readout_o` low.
- R9: `pix_valid_o` is never high on a line where `burst_o` is high.
- R10: A `vd_i` pulse in the middle of a frame, including inside a burst, restarts the frame at line 0, clock 0, with the newly captured mode. The new frame's first transfer starts at once.
- R11: v1 and v2 are never high together, and v3 is high only in the rest state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vd_i | input | 1 | Frame start pulse; captures the mode |
| mode_i | input | 2 | Requested scan mode |
| v1_o | output | 1 | Vertical phase 1 request |
| v2_o | output | 1 | Vertical phase 2 request |
| v3_o | output | 1 | Vertical phase 3 request |
| readout_o | output | 1 | Photodiode readout pulse |
| burst_o | output | 1 | Line belongs to a fast-transfer burst |
| pix_valid_o | output | 1 | Line carries kept pixel data |
| line_o | output | LINE_W | Line index within the frame |
| mode_o | output | 2 | Mode in force for the current frame |

## Verification
A wrong line or clock count shows up on `line_o` and in the segment flags on the very line where it occurs. It then shifts every later segment boundary by whole lines.

A fast-transfer counter that is off in its period, its half-period or its count shows in the phase outputs within one transfer period of the burst start. The number of v1 rises per burst then no longer matches the transfer count, and the rest-state tail has the wrong length.

A mode register that follows `mode_i` outside the sync pulse shows on `mode_o` one cycle after the change. A sequencer that fails to restart on a mid-frame pulse shows on the next clock, as a `line_o` that is not zero and no phase "one".

// File: rtl/cs_vsweep_pkg.sv
package cs_vsweep_pkg;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_WIN_A = 2'd1,
    MODE_WIN_B = 2'd2,
    MODE_RSVD  = 2'd3
  } scan_mode_e;

  typedef enum logic [2:0] {
    SEG_SWEEP = 3'd0,
    SEG_READ  = 3'd1,
    SEG_SHIFT = 3'd2,
    SEG_OUT   = 3'd3,
    SEG_BLANK = 3'd4
  } seg_e;

  // {v1, v2, v3}
  localparam logic [2:0] PH_REST = 3'b011;
  localparam logic [2:0] PH_ONE  = 3'b100;
  localparam logic [2:0] PH_TWO  = 3'b010;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cs_line_timer.sv
module cs_line_timer #(
  parameter int LINE_CLKS = 780,
  parameter int CLK_W     = 10,
  parameter int LINE_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [LINE_W-1:0] last_line_i,
  output logic              run_o,
  output logic [CLK_W-1:0]  clk_cnt_o,
  output logic [LINE_W-1:0] line_o
);

  localparam logic [CLK_W-1:0] CLK_LAST = CLK_W'(LINE_CLKS - 1);

  logic              run_q;
  logic [CLK_W-1:0]  clk_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      clk_q  <= '0;
      line_q <= '0;
    end else if (restart_i) begin
      run_q  <= 1'b1;
      clk_q  <= '0;
      line_q <= '0;
    end else if (run_q) begin
      if (clk_q == CLK_LAST) begin
        clk_q  <= '0;
        line_q <= (line_q >= last_line_i) ? '0 : line_q + LINE_W'(1);
      end else begin
        clk_q <= clk_q + CLK_W'(1);
      end
    end
  end

  assign run_o     = run_q;
  assign clk_cnt_o = clk_q;
  assign line_o    = line_q;

endmodule

// File: rtl/cs_seg_decode.sv
module cs_seg_decode import cs_vsweep_pkg::*; #(
  parameter int LINE_CLKS   = 780,
  parameter int FULL_LINES  = 525,
  parameter int FULL_KEEP   = 494,
  parameter int A_LINES     = 262,
  parameter int A_KEEP      = 222,
  parameter int A_SW_LINES  = 16,
  parameter int A_SW_XFERS  = 167,
  parameter int A_FS_LINES  = 14,
  parameter int A_FS_XFERS  = 142,
  parameter int B_LINES     = 131,
  parameter int B_KEEP      = 76,
  parameter int B_SW_LINES  = 24,
  parameter int B_SW_XFERS  = 255,
  parameter int B_FS_LINES  = 20,
  parameter int B_FS_XFERS  = 215,
  parameter int LINE_W      = 10,
  parameter int XFER_W      = 9,
  parameter int PER_W       = 15
) (
  input  scan_mode_e        mode_i,
  input  logic [LINE_W-1:0] line_i,
  output seg_e              seg_o,
  output logic [LINE_W-1:0] last_line_o,
  output logic [XFER_W-1:0] n_xfer_o,
  output logic [PER_W-1:0]  period_o
);

  // segment ends are exclusive line indices; the readout line sits at sweep end
  localparam int A_FS_END  = A_SW_LINES + 1 + A_FS_LINES;
  localparam int A_OUT_END = A_FS_END + A_KEEP;
  localparam int B_FS_END  = B_SW_LINES + 1 + B_FS_LINES;
  localparam int B_OUT_END = B_FS_END + B_KEEP;
  localparam int F_OUT_END = 1 + FULL_KEEP;

  localparam int A_SW_PER = (A_SW_LINES * LINE_CLKS) / A_SW_XFERS;
  localparam int A_FS_PER = (A_FS_LINES * LINE_CLKS) / A_FS_XFERS;
  localparam int B_SW_PER = (B_SW_LINES * LINE_CLKS) / B_SW_XFERS;
  localparam int B_FS_PER = (B_FS_LINES * LINE_CLKS) / B_FS_XFERS;

  logic [LINE_W-1:0] sw_end, fs_end, out_end;
  logic [XFER_W-1:0] sw_n, fs_n;
  logic [PER_W-1:0]  sw_p, fs_p;

  always_comb begin
    case (mode_i)
      MODE_WIN_A: begin
        sw_end      = LINE_W'(A_SW_LINES);
        fs_end      = LINE_W'(A_FS_END);
        out_end     = LINE_W'(A_OUT_END);
        last_line_o = LINE_W'(A_LINES - 1);
        sw_n        = XFER_W'(A_SW_XFERS);
        fs_n        = XFER_W'(A_FS_XFERS);
        sw_p        = PER_W'(A_SW_PER);
        fs_p        = PER_W'(A_FS_PER);
      end
      MODE_WIN_B: begin
        sw_end      = LINE_W'(B_SW_LINES);
        fs_end      = LINE_W'(B_FS_END);
        out_end     = LINE_W'(B_OUT_END);
        last_line_o = LINE_W'(B_LINES - 1);
        sw_n        = XFER_W'(B_SW_XFERS);
        fs_n        = XFER_W'(B_FS_XFERS);
        sw_p        = PER_W'(B_SW_PER);
        fs_p        = PER_W'(B_FS_PER);
      end
      default: begin
        sw_end      = '0;
        fs_end      = LINE_W'(1);
        out_end     = LINE_W'(F_OUT_END);
        last_line_o = LINE_W'(FULL_LINES - 1);
        sw_n        = '0;
        fs_n        = '0;
        sw_p        = PER_W'(1);
        fs_p        = PER_W'(1);
      end
    endcase
  end

  always_comb begin
    if (line_i < sw_end)        seg_o = SEG_SWEEP;
    else if (line_i == sw_end)  seg_o = SEG_READ;
    else if (line_i < fs_end)   seg_o = SEG_SHIFT;
    else if (line_i < out_end)  seg_o = SEG_OUT;
    else                        seg_o = SEG_BLANK;
  end

  assign n_xfer_o = (seg_o == SEG_SWEEP) ? sw_n : fs_n;
  assign period_o = (seg_o == SEG_SWEEP) ? sw_p : fs_p;

endmodule

// File: rtl/cs_burst_gen.sv
module cs_burst_gen import cs_vsweep_pkg::*; #(
  parameter int XFER_W = 9,
  parameter int PER_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [XFER_W-1:0] n_xfer_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [2:0]        ph_o
);

  logic [XFER_W-1:0] xfer_q;
  logic [PER_W-1:0]  per_q;
  logic [PER_W-1:0]  half;
  logic              busy;

  assign half = period_i >> 1;
  assign busy = (xfer_q < n_xfer_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q <= '0;
      per_q  <= '0;
    end else if (clear_i) begin
      xfer_q <= '0;
      per_q  <= '0;
    end else if (busy) begin
      if (per_q == period_i - PER_W'(1)) begin
        per_q  <= '0;
        xfer_q <= xfer_q + XFER_W'(1);
      end else begin
        per_q <= per_q + PER_W'(1);
      end
    end
  end

  // leftover clocks after the last transfer stay at rest
  assign ph_o = !busy ? PH_REST : ((per_q < half) ? PH_ONE : PH_TWO);

endmodule

// File: rtl/cs_vsweep.sv
module cs_vsweep import cs_vsweep_pkg::*; #(
  parameter int LINE_CLKS  = 780,
  parameter int READ_CLKS  = 60,
  parameter int XFER_CLKS  = 36,
  parameter int FULL_LINES = 525,
  parameter int FULL_KEEP  = 494,
  parameter int A_LINES    = 262,
  parameter int A_KEEP     = 222,
  parameter int A_SW_LINES = 16,
  parameter int A_SW_XFERS = 167,
  parameter int A_FS_LINES = 14,
  parameter int A_FS_XFERS = 142,
  parameter int B_LINES    = 131,
  parameter int B_KEEP     = 76,
  parameter int B_SW_LINES = 24,
  parameter int B_SW_XFERS = 255,
  parameter int B_FS_LINES = 20,
  parameter int B_FS_XFERS = 215,
  localparam int LINE_W    = $clog2(max4(FULL_LINES, A_LINES, B_LINES, 1) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vd_i,
  input  logic [1:0]        mode_i,
  output logic              v1_o,
  output logic              v2_o,
  output logic              v3_o,
  output logic              readout_o,
  output logic              burst_o,
  output logic              pix_valid_o,
  output logic [LINE_W-1:0] line_o,
  output logic [1:0]        mode_o
);

  localparam int CLK_W     = $clog2(LINE_CLKS);
  localparam int MAX_XFERS = max4(A_SW_XFERS, A_FS_XFERS, B_SW_XFERS, B_FS_XFERS);
  localparam int MAX_BLINE = max4(A_SW_LINES, A_FS_LINES, B_SW_LINES, B_FS_LINES);
  localparam int XFER_W    = $clog2(MAX_XFERS + 1);
  localparam int PER_W     = $clog2(LINE_CLKS * MAX_BLINE + 1);

  scan_mode_e        mode_q;
  logic              run;
  logic [CLK_W-1:0]  clk_cnt;
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] last_line;
  seg_e              seg;
  logic [XFER_W-1:0] n_xfer;
  logic [PER_W-1:0]  period;
  logic [2:0]        burst_ph, slow_ph, ph;
  logic              burst_act;
  logic              burst_d, pv_d, rd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      mode_q <= MODE_FULL;
    else if (vd_i)
      mode_q <= (mode_i == MODE_RSVD) ? MODE_FULL : scan_mode_e'(mode_i);
  end

  cs_line_timer #(
    .LINE_CLKS (LINE_CLKS),
    .CLK_W     (CLK_W),
    .LINE_W    (LINE_W)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (vd_i),
    .last_line_i (last_line),
    .run_o       (run),
    .clk_cnt_o   (clk_cnt),
    .line_o      (line)
  );

  cs_seg_decode #(
    .LINE_CLKS  (LINE_CLKS),
    .FULL_LINES (FULL_LINES),
    .FULL_KEEP  (FULL_KEEP),
    .A_LINES    (A_LINES),
    .A_KEEP     (A_KEEP),
    .A_SW_LINES (A_SW_LINES),
    .A_SW_XFERS (A_SW_XFERS),
    .A_FS_LINES (A_FS_LINES),
    .A_FS_XFERS (A_FS_XFERS),
    .B_LINES    (B_LINES),
    .B_KEEP     (B_KEEP),
    .B_SW_LINES (B_SW_LINES),
    .B_SW_XFERS (B_SW_XFERS),
    .B_FS_LINES (B_FS_LINES),
    .B_FS_XFERS (B_FS_XFERS),
    .LINE_W     (LINE_W),
    .XFER_W     (XFER_W),
    .PER_W      (PER_W)
  ) u_decode (
    .mode_i      (mode_q),
    .line_i      (line),
    .seg_o       (seg),
    .last_line_o (last_line),
    .n_xfer_o    (n_xfer),
    .period_o    (period)
  );

  assign burst_act = run && ((seg == SEG_SWEEP) || (seg == SEG_SHIFT));

  cs_burst_gen #(
    .XFER_W (XFER_W),
    .PER_W  (PER_W)
  ) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (vd_i || !burst_act),
    .n_xfer_i (n_xfer),
    .period_i (period),
    .ph_o     (burst_ph)
  );

  // one slow transfer at the head of each kept line
  always_comb begin
    if (clk_cnt < CLK_W'(XFER_CLKS))          slow_ph = PH_ONE;
    else if (clk_cnt < CLK_W'(2 * XFER_CLKS)) slow_ph = PH_TWO;
    else                                      slow_ph = PH_REST;
  end

  always_comb begin
    ph      = PH_REST;
    burst_d = 1'b0;
    pv_d    = 1'b0;
    rd_d    = 1'b0;
    if (run) begin
      case (seg)
        SEG_SWEEP, SEG_SHIFT: begin
          burst_d = 1'b1;
          ph      = burst_ph;
        end
        SEG_READ: rd_d = (clk_cnt < CLK_W'(READ_CLKS));
        SEG_OUT: begin
          pv_d = 1'b1;
          ph   = slow_ph;
        end
        default: ;
      endcase
    end
  end

  assign v1_o        = ph[2];
  assign v2_o        = ph[1];
  assign v3_o        = ph[0];
  assign burst_o     = burst_d;
  assign pix_valid_o = pv_d;
  assign readout_o   = rd_d;
  assign line_o      = line;
  assign mode_o      = mode_q;

endmodule

// File: rtl/cs_vsweep_chk.sv
module cs_vsweep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vd_i,
  input logic       v1_o,
  input logic       v2_o,
  input logic       v3_o,
  input logic       readout_o,
  input logic       burst_o,
  input logic       pix_valid_o,
  input logic [1:0] mode_o
);

  assert_no_valid_in_burst_R9: assert property (
    @(posedge clk_i) disable iff (!rst_ni) burst_o |-> !pix_valid_o);

  assert_phase_excl_R11: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !(v1_o && v2_o));

  assert_v3_rest_only_R11: assert property (
    @(posedge clk_i) disable iff (!rst_ni) v3_o |-> (v2_o && !v1_o));

  assert_mode_hold_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !vd_i |=> $stable(mode_o));

  assert_mode_legal_R2: assert property (
    @(posedge clk_i) disable iff (!rst_ni) mode_o != 2'd3);

  assert_readout_quiet_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
      readout_o |-> (!burst_o && !pix_valid_o && !v1_o));

endmodule

bind cs_vsweep cs_vsweep_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vd_i        (vd_i),
  .v1_o        (v1_o),
  .v2_o        (v2_o),
  .v3_o        (v3_o),
  .readout_o   (readout_o),
  .burst_o     (burst_o),
  .pix_valid_o (pix_valid_o),
  .mode_o      (mode_o)
);

// File: tb/cs_vsweep_test.sv
module cs_vsweep_test;

  localparam int L  = 40;
  localparam int RD = 8;
  localparam int XF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vd = 1'b0;
  logic [1:0] mode_in = 2'd0;
  logic       v1, v2, v3, rd, burst, pv;
  logic [9:0] line_o;
  logic [1:0] mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cs_vsweep #(
    .LINE_CLKS (L),
    .READ_CLKS (RD),
    .XFER_CLKS (XF)
  ) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vd_i        (vd),
    .mode_i      (mode_in),
    .v1_o        (v1),
    .v2_o        (v2),
    .v3_o        (v3),
    .readout_o   (rd),
    .burst_o     (burst),
    .pix_valid_o (pv),
    .line_o      (line_o),
    .mode_o      (mode_o)
  );

  // stimulus mode, expected accepted mode
  localparam logic [3:0] VEC [4] = '{4'b0101, 4'b1010, 4'b0000, 4'b1100};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int frame_lines(input int m);
    if (m == 1) return 262;
    if (m == 2) return 131;
    return 525;
  endfunction

  // per-mode sweep lines, sweep transfers, shift lines, shift transfers, kept lines
  function automatic void geom(input int m, output int sw, output int swn,
                               output int fs, output int fsn, output int keep);
    if (m == 1)      begin sw = 16; swn = 167; fs = 14; fsn = 142; keep = 222; end
    else if (m == 2) begin sw = 24; swn = 255; fs = 20; fsn = 215; keep = 76; end
    else             begin sw = 0;  swn = 0;   fs = 0;  fsn = 0;   keep = 494; end
  endfunction

  function automatic int seg_of(input int m, input int ln);
    int sw, swn, fs, fsn, keep;
    geom(m, sw, swn, fs, fsn, keep);
    if (ln < sw) return 0;
    if (ln == sw) return 1;
    if (ln <= sw + fs) return 2;
    if (ln <= sw + fs + keep) return 3;
    return 4;
  endfunction

  function automatic logic [2:0] fast_ph(input int off, input int p, input int n);
    if (off >= p * n) return 3'b011;
    return ((off % p) < (p / 2)) ? 3'b100 : 3'b010;
  endfunction

  // {v1, v2, v3, burst, pix_valid, readout}
  function automatic logic [5:0] exp_out(input int m, input int ln, input int ck);
    int sw, swn, fs, fsn, keep, s;
    logic [2:0] ph;
    geom(m, sw, swn, fs, fsn, keep);
    s = seg_of(m, ln);
    case (s)
      0: return {fast_ph(ln * L + ck, (sw * L) / swn, swn), 3'b100};
      1: return {3'b011, 2'b00, (ck < RD) ? 1'b1 : 1'b0};
      2: return {fast_ph((ln - sw - 1) * L + ck, (fs * L) / fsn, fsn), 3'b100};
      3: begin
        ph = (ck < XF) ? 3'b100 : (ck < 2 * XF) ? 3'b010 : 3'b011;
        return {ph, 3'b010};
      end
      default: return 6'b011000;
    endcase
  endfunction

  task automatic start_frame(input logic [1:0] m);
    @(negedge clk);
    vd = 1'b1;
    mode_in = m;
    @(negedge clk);
    vd = 1'b0;
    mode_in = m + 2'd1;  // later changes must be ignored
  endtask

  task automatic scan_frame(input int m);
    string tags [5] = '{"R4", "R5", "R6", "R7", "R8"};
    int err [5] = '{0, 0, 0, 0, 0};
    int fa [5] = '{0, 0, 0, 0, 0};
    int fe [5] = '{0, 0, 0, 0, 0};
    int ln_err = 0, r9_err = 0, r11_err = 0, rise_sw = 0, rise_fs = 0;
    int sw, swn, fs, fsn, keep;
    bit pv1 = 1'b0;
    geom(m, sw, swn, fs, fsn, keep);
    for (int ln = 0; ln < frame_lines(m); ln++) begin
      for (int ck = 0; ck < L; ck++) begin
        logic [5:0] e, a;
        int s;
        e = exp_out(m, ln, ck);
        s = seg_of(m, ln);
        a = {v1, v2, v3, burst, pv, rd};
        if (a !== e) begin
          if (err[s] == 0) begin fa[s] = int'(a); fe[s] = int'(e); end
          err[s]++;
        end
        if (int'(line_o) != ln) ln_err++;
        if (burst && pv) r9_err++;
        if ((v1 && v2) || (v3 && !(v2 && !v1))) r11_err++;
        if (burst && v1 && !pv1) begin
          if (s == 0) rise_sw++; else rise_fs++;
        end
        pv1 = v1;
        @(negedge clk);
      end
    end
    for (int s = 0; s < 5; s++)
      if (m == 1 || m == 2 || (s != 0 && s != 2))
        check(err[s] == 0, tags[s], $sformatf("mode %0d segment outputs", m), fa[s], fe[s]);
    check(ln_err == 0, "R3", "line index mismatches", ln_err, 0);
    check(r9_err == 0, "R9", "valid during burst", r9_err, 0);
    check(r11_err == 0, "R11", "illegal phase combination", r11_err, 0);
    if (m == 1 || m == 2) begin
      check(rise_sw == swn, "R4", "sweep transfer count", rise_sw, swn);
      check(rise_fs == fsn, "R6", "shift transfer count", rise_fs, fsn);
    end
    // frame wraps without a new sync pulse
    check(line_o == 10'd0, "R3", "line after wrap", int'(line_o), 0);
    check({v1, v2, v3, burst, pv, rd} === exp_out(m, 0, 0), "R3", "outputs after wrap",
          int'({v1, v2, v3, burst, pv, rd}), int'(exp_out(m, 0, 0)));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({v1, v2, v3, burst, pv, rd} === 6'b011000, "R1", "idle outputs",
          int'({v1, v2, v3, burst, pv, rd}), 24);
    check(line_o == 10'd0, "R1", "idle line", int'(line_o), 0);
    check(mode_o == 2'd0, "R1", "idle mode", int'(mode_o), 0);
    mode_in = 2'd2;
    repeat (3) @(negedge clk);
    check(mode_o == 2'd0, "R2", "mode without sync", int'(mode_o), 0);
    check(v1 == 1'b0 && burst == 1'b0, "R1", "still idle before sync",
          int'({v1, burst}), 0);

    for (int i = 0; i < 4; i++) begin
      logic [1:0] mi, me;
      mi = VEC[i][3:2];
      me = VEC[i][1:0];
      start_frame(mi);
      check(mode_o == me, "R2", $sformatf("accepted mode for code %0d", mi),
            int'(mode_o), int'(me));
      scan_frame(int'(me));
    end

    // R10: sync in the middle of a sweep burst
    start_frame(2'd2);
    repeat (5 * L + 7) @(negedge clk);
    check(burst == 1'b1, "R10", "inside burst before restart", int'(burst), 1);
    start_frame(2'd1);
    check(line_o == 10'd0 && mode_o == 2'd1, "R10", "restart line/mode",
          int'({line_o, mode_o}), 1);
    check({v1, v2, v3} == 3'b100 && burst, "R10", "first transfer on restart",
          int'({v1, v2, v3, burst}), 9);
    scan_frame(1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule